// File: doc/BRIEF.md
# Configurable Registered Address Buffer

This block is a single register stage placed on a memory module between the controller and the DRAM devices. On each rising clock edge it captures command and address bits and presents them on flip-flop outputs one clock later. Two strap inputs select how it is wired. With the fanout strap low, it carries a straight 25-bit path. With the fanout strap high, it carries a 14-bit path in which every captured bit drives two outputs.

In the doubled mode, the swizzle strap chooses one of two output arrangements. In the linear arrangement, the captured word appears twice, side by side. In the interleaved arrangement, each bit drives two adjacent outputs. The straps are meant to be tied off; they are only changed while reset is held.

Two active-low select inputs are sampled on the same clock edge as the data. When both are high, that edge's capture is suppressed and the outputs keep their values, which saves switching power. An asynchronous active-low reset clears the register at once.

Top module: `regbuf_top`

## Requirements
- R1: While `rst_n` is low, `q_out` is all zero. It goes to zero as soon as `rst_n` falls, without waiting for a clock edge, and it stays zero through clock edges while `rst_n` is held low.
- R2: With `cfg_fanout`=0, after a loading rising edge `q_out[i]` equals the `d_in[i]` sampled at that edge, for i = 0..24.
- R3: With `cfg_fanout`=1 and `cfg_swizzle`=0, after a loading edge both `q_out[i]` and `q_out[i+14]` equal the sampled `d_in[i]`, for i = 0..13.
- R4: With `cfg_fanout`=1 and `cfg_swizzle`=1, after a loading edge both `q_out[2i]` and `q_out[2i+1]` equal the sampled `d_in[i]`, for i = 0..13.
- R5: `q_out` changes only at a rising clock edge (or on reset). Input changes between edges have no effect on it.
- R6: If `cs_dimm_n` and `cs_rank_n` are both high at a rising edge, `q_out` keeps its previous value across that edge.
- R7: If at least one of `cs_dimm_n` or `cs_rank_n` is low at a rising edge, that edge is a loading edge and `q_out` takes the newly mapped data.
- R8: With `cfg_fanout`=1, `d_in[24:14]` has no effect on `q_out`.
- R9: With `cfg_fanout`=0, `q_out[27:25]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fanout | input | 1 | Strap: 0 = 25-bit one-to-one, 1 = 14-bit one-to-two |
| cfg_swizzle | input | 1 | Strap for one-to-two mode: 0 = linear, 1 = interleaved |
| cs_dimm_n | input | 1 | Select input, active low; update is blocked only when both selects are high |
| cs_rank_n | input | 1 | Second select input, active low |
| d_in | input | 25 | Command and address bits to capture |
| q_out | output | 28 | Registered, mapped outputs |

## Verification
On every clock, the assertions check the following:
- the hold when both selects are high;
- the one-cycle data path in the 25-bit mode;
- the zero spare outputs;
- the duplicate relation between output pairs in both doubled arrangements.

Some behaviour can only be shown by the bench's scenarios:
- the absolute placement of each captured bit, which it shows with single-bit and alternating patterns;
- the asynchronous clear arriving without a clock edge;
- that no output moves between edges;
- that the unused upper inputs are ignored in the doubled mode.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

  typedef enum logic [1:0] {
    MAP_WIDE             = 2'd0,
    MAP_SPLIT_LINEAR     = 2'd1,
    MAP_SPLIT_INTERLEAVE = 2'd2
  } map_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/regbuf_strap_decode.sv
module regbuf_strap_decode
  import regbuf_pkg::*;
(
  input  logic      fanout_i,
  input  logic      swizzle_i,
  output map_mode_e mode_o
);

  always_comb begin
    if (!fanout_i)      mode_o = MAP_WIDE;
    else if (swizzle_i) mode_o = MAP_SPLIT_INTERLEAVE;
    else                mode_o = MAP_SPLIT_LINEAR;
  end

endmodule

// File: rtl/regbuf_fanout_map.sv
module regbuf_fanout_map
  import regbuf_pkg::*;
#(
  parameter int WIDE_BITS   = 25,
  parameter int NARROW_BITS = 14,
  parameter int OUT_BITS    = max_int(WIDE_BITS, 2 * NARROW_BITS)
) (
  input  map_mode_e             mode_i,
  input  logic [WIDE_BITS-1:0]  data_i,
  output logic [OUT_BITS-1:0]   mapped_o
);

  localparam int SPLIT_SPAN = 2 * NARROW_BITS;

  for (genvar o = 0; o < OUT_BITS; o++) begin : g_slot
    logic wide_bit;
    logic linear_bit;
    logic interleave_bit;

    // One-to-one path; slots above the input width stay low.
    if (o < WIDE_BITS) begin : g_wide
      assign wide_bit = data_i[o];
    end else begin : g_wide_pad
      assign wide_bit = 1'b0;
    end

    // Linear doubling: the word, then the same word again.
    if (o < NARROW_BITS) begin : g_lin_lo
      assign linear_bit = data_i[o];
    end else if (o < SPLIT_SPAN) begin : g_lin_hi
      assign linear_bit = data_i[o - NARROW_BITS];
    end else begin : g_lin_pad
      assign linear_bit = 1'b0;
    end

    // Interleaved doubling: each bit drives an adjacent pair.
    if (o < SPLIT_SPAN) begin : g_ilv
      assign interleave_bit = data_i[o / 2];
    end else begin : g_ilv_pad
      assign interleave_bit = 1'b0;
    end

    assign mapped_o[o] = (mode_i == MAP_WIDE)         ? wide_bit   :
                         (mode_i == MAP_SPLIT_LINEAR) ? linear_bit :
                                                        interleave_bit;
  end

endmodule

// File: rtl/regbuf_capture_gate.sv
module regbuf_capture_gate (
  input  logic sel_a_n_i,
  input  logic sel_b_n_i,
  output logic load_en_o
);

  // A capture is allowed when at least one select is active (low).
  always_comb load_en_o = ~(sel_a_n_i & sel_b_n_i);

endmodule

// File: rtl/regbuf_top.sv
module regbuf_top
  import regbuf_pkg::*;
#(
  parameter int WIDE_BITS   = 25,
  parameter int NARROW_BITS = 14,
  parameter int OUT_BITS    = max_int(WIDE_BITS, 2 * NARROW_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_fanout,
  input  logic                 cfg_swizzle,
  input  logic                 cs_dimm_n,
  input  logic                 cs_rank_n,
  input  logic [WIDE_BITS-1:0] d_in,
  output logic [OUT_BITS-1:0]  q_out
);

  localparam int SPLIT_SPAN = 2 * NARROW_BITS;

  function automatic logic [OUT_BITS-1:0] even_pair_mask();
    logic [OUT_BITS-1:0] m;
    m = '0;
    for (int k = 0; k < SPLIT_SPAN; k += 2) m[k] = 1'b1;
    return m;
  endfunction

  localparam logic [OUT_BITS-1:0] EVEN_MASK = even_pair_mask();

  map_mode_e           mode;
  logic [OUT_BITS-1:0] mapped;
  logic                load_en;
  logic [OUT_BITS-1:0] q_reg;

  regbuf_strap_decode i_strap (
    .fanout_i  (cfg_fanout),
    .swizzle_i (cfg_swizzle),
    .mode_o    (mode)
  );

  regbuf_fanout_map #(
    .WIDE_BITS   (WIDE_BITS),
    .NARROW_BITS (NARROW_BITS),
    .OUT_BITS    (OUT_BITS)
  ) i_map (
    .mode_i   (mode),
    .data_i   (d_in),
    .mapped_o (mapped)
  );

  regbuf_capture_gate i_gate (
    .sel_a_n_i (cs_dimm_n),
    .sel_b_n_i (cs_rank_n),
    .load_en_o (load_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_reg <= '0;
    else if (load_en) q_reg <= mapped;
  end

  assign q_out = q_reg;

  AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_dimm_n && cs_rank_n) |=> $stable(q_out)); // R6

  AST_WIDE_PASSTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fanout && !(cs_dimm_n && cs_rank_n)) |=> (q_out == OUT_BITS'($past(d_in)))); // R2

  AST_SPARE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fanout |-> (q_out[OUT_BITS-1:WIDE_BITS] == '0)); // R9

  AST_LINEAR_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fanout && !cfg_swizzle) |->
      (q_out[NARROW_BITS-1:0] == q_out[SPLIT_SPAN-1:NARROW_BITS])); // R3

  AST_INTERLEAVE_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fanout && cfg_swizzle) |-> (((q_out ^ (q_out >> 1)) & EVEN_MASK) == '0)); // R4

endmodule

// File: tb/test_regbuf_top.sv
`timescale 1ns/1ps
module test_regbuf_top;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;  // 0 wide, 1 linear, 2 interleaved
    logic        dcs_n;
    logic        csr_n;
    logic [24:0] d;
    logic [27:0] exp_q;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 1'b0, 25'h1FFFFFF, 28'h1FFFFFF}, // R2 R9 all ones
    '{2'd0, 1'b1, 1'b0, 25'h0AAAAAA, 28'h0AAAAAA}, // R7 one select low
    '{2'd0, 1'b0, 1'b1, 25'h1555555, 28'h1555555}, // R7 other select low
    '{2'd0, 1'b1, 1'b1, 25'h0000000, 28'h1555555}, // R6 hold
    '{2'd0, 1'b0, 1'b0, 25'h1000000, 28'h1000000}, // R2 top bit
    '{2'd1, 1'b0, 1'b0, 25'h0000001, 28'h0004001}, // R3 bit 0
    '{2'd1, 1'b0, 1'b0, 25'h0002000, 28'h8002000}, // R3 bit 13
    '{2'd1, 1'b1, 1'b1, 25'h0003FFF, 28'h8002000}, // R6 hold
    '{2'd1, 1'b1, 1'b0, 25'h1FFC000, 28'h0000000}, // R8 upper ignored
    '{2'd1, 1'b0, 1'b1, 25'h0003FFF, 28'hFFFFFFF}, // R3 all ones
    '{2'd2, 1'b0, 1'b0, 25'h0000001, 28'h0000003}, // R4 bit 0
    '{2'd2, 1'b0, 1'b0, 25'h0002000, 28'hC000000}, // R4 bit 13
    '{2'd2, 1'b0, 1'b0, 25'h0000155, 28'h0033333}, // R4 even bits
    '{2'd2, 1'b1, 1'b1, 25'h1FFFFFF, 28'h0033333}, // R6 hold
    '{2'd2, 1'b0, 1'b0, 25'h1FFC0AA, 28'h000CCCC}  // R4 R8 odd bits, upper ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fanout = 1'b0;
  logic        cfg_swizzle = 1'b0;
  logic        cs_dimm_n = 1'b1;
  logic        cs_rank_n = 1'b1;
  logic [24:0] d_in = '0;
  logic [27:0] q_out;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  regbuf_top i_regbuf_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fanout  (cfg_fanout),
    .cfg_swizzle (cfg_swizzle),
    .cs_dimm_n   (cs_dimm_n),
    .cs_rank_n   (cs_rank_n),
    .d_in        (d_in),
    .q_out       (q_out)
  );

  task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] mode);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_fanout  = (mode != 2'd0);
    cfg_swizzle = (mode == 2'd2);
    cs_dimm_n = 1'b1;
    cs_rank_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: q_out=%h expected run to end", q_out);
    finish_run();
  end

  initial begin
    logic [1:0] cur_mode;

    // R1: reset state
    apply_reset(2'd0);
    check("R1 reset state", q_out, 28'h0);
    cur_mode = 2'd0;

    // Table walk: inputs set at a falling edge, result read at the next falling edge.
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].mode != cur_mode) begin
        apply_reset(VECS[v].mode);
        cur_mode = VECS[v].mode;
      end
      cs_dimm_n = VECS[v].dcs_n;
      cs_rank_n = VECS[v].csr_n;
      d_in      = VECS[v].d;
      @(negedge clk);
      check($sformatf("vector %0d (R2 R3 R4 R6 R7 R8)", v), q_out, VECS[v].exp_q);
    end

    // R9: spare outputs stay low in the wide mode, even with all inputs high
    apply_reset(2'd0);
    cs_dimm_n = 1'b0;
    cs_rank_n = 1'b0;
    d_in = 25'h1FFFFFF;
    @(negedge clk);
    check("R9 spare outputs", {q_out[27:25], 25'h0}, 28'h0);

    // R5: a mid-cycle input change is not seen until the next rising edge
    d_in = 25'h0F0F0F0;
    #(CLK_PERIOD / 4);
    check("R5 no change between edges", q_out, 28'h1FFFFFF);
    @(negedge clk);
    check("R5 update at edge", q_out, 28'h0F0F0F0);

    // R1: the clear is asynchronous; q_out is checked before any clock edge
    #1;
    rst_n = 1'b0;
    #1;
    check("R1 asynchronous clear", q_out, 28'h0);
    @(negedge clk);
    check("R1 held through edge", q_out, 28'h0);
    rst_n = 1'b1;

    // R7: after reset, a single active select loads interleaved data
    apply_reset(2'd2);
    cs_dimm_n = 1'b1;
    cs_rank_n = 1'b0;
    d_in = 25'h0000002;
    @(negedge clk);
    check("R7 load after reset", q_out, 28'h000000C);

    // R6: hold persists over several edges
    cs_rank_n = 1'b1;
    d_in = 25'h0003FFF;
    @(negedge clk);
    @(negedge clk);
    check("R6 multi-edge hold", q_out, 28'h000000C);

    finish_run();
  end

endmodule